// File: doc/BRIEF.md
# Core-Aware Learned Request Scheduler

This block chooses which entry of a shared DRAM request queue goes next when the queue is filled by several cores. It tracks the occupancy of every slot: the owning core, the target bank, whether the request hits the open row, and how long the slot has waited. From this it derives four runtime features for each core: pending count, row-hit count, recent arrival activity, and a bank-parallelism count that all cores share. Each core has its own weight vector. The core's score is a signed fixed-point linear value of its features. The core with the best score that has a ready request is favoured. Within that core, row hits go first and then the oldest request.

A learning agent outside the block writes the weights through an update port. Enqueue and dequeue events arrive as slot-indexed strobes. A per-slot ready mask, driven by the DRAM timing logic, says which requests may issue now. A three-state decision machine paces the work. In S_IDLE the queue is empty and no grant is shown. Leaving S_IDLE ("arm") happens once any slot is occupied and goes to S_SCORE. S_SCORE latches every core's score and always moves on ("latch") to S_ISSUE. S_ISSUE registers the selection. From there it goes either back to S_SCORE ("repeat") while slots remain occupied, or to S_IDLE ("drain") when the queue is empty.

Top module: `core_learned_sched`

## Requirements
- R1: After reset `grant_valid` is low and all weights are zero, so every core scores zero.
- R2: Feature 1 of a core is the number of occupied slots it owns, saturating at 8 bits.
- R3: Feature 2 of a core is the number of its occupied slots marked as row hits.
- R4: Feature 3 of a core is the number of cycles among the last 16 in which an enqueue tagged with that core arrived.
- R5: Feature 4, common to all cores, is the number of distinct banks targeted by occupied slots.
- R6: A core's score is theta0 + theta1·f1 + theta2·f2 + theta3·f3 + theta4·f4, where the weights are signed 16-bit Q8.8, the features are unsigned integers, and the sum is a 32-bit signed value.
- R7: The granted core is the one with the highest score among cores that own at least one occupied and ready slot; equal scores go to the lower core ID.
- R8: Within the granted core, a ready row-hit slot beats a ready non-hit slot, then the longest-waiting slot wins, then the lower slot index.
- R9: When no occupied slot is ready, `grant_valid` is low.
- R10: A write with `wt_idx` 0 (bias) to 4 (feature 4) sets that weight of core `wt_core`, and the following decision uses it (visible at the outputs within 6 cycles). Index values above 4 are ignored.
- R11: An enqueue occupies its slot with age zero. A dequeue frees its slot. If both hit the same slot in one cycle, the slot holds the new request. A dequeue of a free slot changes nothing.
- R12: The machine goes S_SCORE to S_ISSUE on every pass. The grant output changes only on leaving S_ISSUE and is cleared in S_IDLE, so an emptied queue drops `grant_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_slot | input | $clog2(QDEPTH) | Slot receiving the request |
| enq_core | input | $clog2(NCORE) | Issuing core |
| enq_bank | input | $clog2(NBANK) | Target bank |
| enq_hit | input | 1 | Request hits the open row |
| deq_valid | input | 1 | Dequeue strobe |
| deq_slot | input | $clog2(QDEPTH) | Slot being freed |
| ready_mask | input | QDEPTH | Per-slot ready flags from timing logic |
| wt_we | input | 1 | Weight write strobe |
| wt_core | input | $clog2(NCORE) | Core whose weight is written |
| wt_idx | input | 3 | Weight index, 0 bias, 1..4 features |
| wt_data | input | WT_W | Signed Q8.8 weight value |
| grant_valid | output | 1 | A selection is presented |
| grant_slot | output | $clog2(QDEPTH) | Selected slot |
| grant_core | output | $clog2(NCORE) | Core owning the selected slot |

## Verification
The bench uses the default build: four cores, eight slots, four banks and a 16-cycle history. At this size the whole queue fits in a short loop. A seeded sweep can fill any subset of slots with arbitrary owners, banks, row-hit flags and ready flags, and give every core random signed weights. The expected grant is then recomputed arithmetically from R2 to R8. Directed sequences cover history decay over 16 cycles, weight swaps, simultaneous enqueue and dequeue on one slot, and queue drain.

// File: rtl/cls_pkg.sv
package cls_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCORE = 2'd1,
        S_ISSUE = 2'd2
    } dec_state_e;

    localparam int NFEAT = 4;
endpackage

// File: rtl/cls_history.sv
module cls_history #(
    parameter int HIST_LEN = 16,
    parameter int FEAT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive,
    output logic [FEAT_W-1:0] level
);
    localparam int FEAT_MAX = (1 << FEAT_W) - 1;

    logic [HIST_LEN-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= {bits_q[HIST_LEN-2:0], arrive};
    end

    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < HIST_LEN; i++) cnt += int'(bits_q[i]);
        level = (cnt > FEAT_MAX) ? '1 : FEAT_W'(cnt);
    end

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> bits_q[0]);
endmodule

// File: rtl/cls_score.sv
module cls_score #(
    parameter int NFEAT   = 4,
    parameter int FEAT_W  = 8,
    parameter int WT_W    = 16,
    parameter int SCORE_W = 32
) (
    input  logic [NFEAT-1:0][FEAT_W-1:0] feat,
    input  logic [NFEAT:0][WT_W-1:0]     theta,
    output logic signed [SCORE_W-1:0]    score
);
    localparam int PW = WT_W + FEAT_W + 1;

    always_comb begin
        logic signed [SCORE_W-1:0] acc;
        logic signed [PW-1:0]      prod;
        acc = {{(SCORE_W-WT_W){theta[0][WT_W-1]}}, theta[0]};
        for (int k = 0; k < NFEAT; k++) begin
            prod = PW'($signed(theta[k+1]) * $signed({1'b0, feat[k]}));
            acc  = acc + {{(SCORE_W-PW){prod[PW-1]}}, prod};
        end
        score = acc;
    end
endmodule

// File: rtl/cls_pick.sv
module cls_pick #(
    parameter int QDEPTH  = 8,
    parameter int NCORE   = 4,
    parameter int SCORE_W = 32,
    parameter int AGE_W   = 8,
    parameter int SLOT_W  = $clog2(QDEPTH),
    parameter int CORE_W  = $clog2(NCORE)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [QDEPTH-1:0]         cand,
    input  logic [CORE_W-1:0]         ent_core [QDEPTH],
    input  logic [QDEPTH-1:0]         ent_hit,
    input  logic [AGE_W-1:0]          ent_age  [QDEPTH],
    input  logic signed [SCORE_W-1:0] scores   [NCORE],
    output logic                      pick_valid,
    output logic [SLOT_W-1:0]         pick_slot,
    output logic [CORE_W-1:0]         pick_core
);
    logic [NCORE-1:0] core_rdy;

    always_comb begin
        logic                      cfound, sfound, bhit;
        logic signed [SCORE_W-1:0] bscore;
        logic [AGE_W-1:0]          bage;
        core_rdy = '0;
        for (int q = 0; q < QDEPTH; q++)
            if (cand[q]) core_rdy[ent_core[q]] = 1'b1;
        cfound = 1'b0; bscore = '0; pick_core = '0;
        for (int c = 0; c < NCORE; c++) begin
            if (core_rdy[c] && (!cfound || scores[c] > bscore)) begin
                cfound = 1'b1; bscore = scores[c]; pick_core = CORE_W'(c);
            end
        end
        sfound = 1'b0; bhit = 1'b0; bage = '0; pick_slot = '0;
        for (int q = 0; q < QDEPTH; q++) begin
            if (cand[q] && ent_core[q] == pick_core &&
                (!sfound || (ent_hit[q] && !bhit) ||
                 (ent_hit[q] == bhit && ent_age[q] > bage))) begin
                sfound = 1'b1; bhit = ent_hit[q]; bage = ent_age[q];
                pick_slot = SLOT_W'(q);
            end
        end
        pick_valid = cfound;
    end

    // R8
    pick_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (cand[pick_slot] && ent_core[pick_slot] == pick_core));
endmodule

// File: rtl/core_learned_sched.sv
module core_learned_sched
    import cls_pkg::*;
#(
    parameter int NCORE    = 4,
    parameter int QDEPTH   = 8,
    parameter int NBANK    = 4,
    parameter int HIST_LEN = 16,
    parameter int FEAT_W   = 8,
    parameter int WT_W     = 16,
    parameter int SCORE_W  = 32,
    parameter int AGE_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    input  logic [$clog2(QDEPTH)-1:0] enq_slot,
    input  logic [$clog2(NCORE)-1:0]  enq_core,
    input  logic [$clog2(NBANK)-1:0]  enq_bank,
    input  logic                      enq_hit,
    input  logic                      deq_valid,
    input  logic [$clog2(QDEPTH)-1:0] deq_slot,
    input  logic [QDEPTH-1:0]         ready_mask,
    input  logic                      wt_we,
    input  logic [$clog2(NCORE)-1:0]  wt_core,
    input  logic [2:0]                wt_idx,
    input  logic [WT_W-1:0]           wt_data,
    output logic                      grant_valid,
    output logic [$clog2(QDEPTH)-1:0] grant_slot,
    output logic [$clog2(NCORE)-1:0]  grant_core
);
    localparam int SLOT_W   = $clog2(QDEPTH);
    localparam int CORE_W   = $clog2(NCORE);
    localparam int BANK_W   = $clog2(NBANK);
    localparam int FEAT_MAX = (1 << FEAT_W) - 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // slot table
    logic [QDEPTH-1:0] ent_valid, ent_hit;
    logic [CORE_W-1:0] ent_core [QDEPTH];
    logic [BANK_W-1:0] ent_bank [QDEPTH];
    logic [AGE_W-1:0]  ent_age  [QDEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_hit   <= '0;
            for (int q = 0; q < QDEPTH; q++) begin
                ent_core[q] <= '0;
                ent_bank[q] <= '0;
                ent_age[q]  <= '0;
            end
        end else begin
            for (int q = 0; q < QDEPTH; q++) begin
                if (ent_valid[q] && ent_age[q] != AGE_MAX)
                    ent_age[q] <= ent_age[q] + 1'b1;
                if (deq_valid && deq_slot == SLOT_W'(q))
                    ent_valid[q] <= 1'b0;
                if (enq_valid && enq_slot == SLOT_W'(q)) begin
                    ent_valid[q] <= 1'b1;
                    ent_core[q]  <= enq_core;
                    ent_bank[q]  <= enq_bank;
                    ent_hit[q]   <= enq_hit;
                    ent_age[q]   <= '0;
                end
            end
        end
    end

    // feature extraction
    function automatic logic [FEAT_W-1:0] sat_feat(input int v);
        return (v > FEAT_MAX) ? '1 : FEAT_W'(v);
    endfunction

    logic [NFEAT-1:0][FEAT_W-1:0] feat     [NCORE];
    logic [FEAT_W-1:0]            hist_lvl [NCORE];
    logic [NBANK-1:0]             bank_busy;

    always_comb begin
        int nb, np, nh;
        bank_busy = '0;
        for (int q = 0; q < QDEPTH; q++)
            if (ent_valid[q]) bank_busy[ent_bank[q]] = 1'b1;
        nb = 0;
        for (int b = 0; b < NBANK; b++) nb += int'(bank_busy[b]);
        for (int c = 0; c < NCORE; c++) begin
            np = 0; nh = 0;
            for (int q = 0; q < QDEPTH; q++) begin
                if (ent_valid[q] && ent_core[q] == CORE_W'(c)) begin
                    np += 1;
                    nh += int'(ent_hit[q]);
                end
            end
            feat[c][0] = sat_feat(np);
            feat[c][1] = sat_feat(nh);
            feat[c][2] = hist_lvl[c];
            feat[c][3] = sat_feat(nb);
        end
    end

    // weights
    logic [NFEAT:0][WT_W-1:0] theta [NCORE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCORE; c++) theta[c] <= '0;
        end else if (wt_we && wt_idx <= 3'(NFEAT)) begin
            theta[wt_core][wt_idx] <= wt_data;
        end
    end

    // per-core history and score
    logic signed [SCORE_W-1:0] score_now [NCORE];
    logic signed [SCORE_W-1:0] score_q   [NCORE];

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        cls_history #(.HIST_LEN(HIST_LEN), .FEAT_W(FEAT_W)) u_hist (
            .clk(clk), .rst_n(rst_n),
            .arrive(enq_valid && enq_core == CORE_W'(c)),
            .level(hist_lvl[c])
        );
        cls_score #(.NFEAT(NFEAT), .FEAT_W(FEAT_W), .WT_W(WT_W),
                    .SCORE_W(SCORE_W)) u_score (
            .feat(feat[c]), .theta(theta[c]), .score(score_now[c])
        );
    end

    // selection
    logic              pick_valid;
    logic [SLOT_W-1:0] pick_slot;
    logic [CORE_W-1:0] pick_core;

    cls_pick #(.QDEPTH(QDEPTH), .NCORE(NCORE), .SCORE_W(SCORE_W),
               .AGE_W(AGE_W), .SLOT_W(SLOT_W), .CORE_W(CORE_W)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .cand(ent_valid & ready_mask),
        .ent_core(ent_core), .ent_hit(ent_hit), .ent_age(ent_age),
        .scores(score_q),
        .pick_valid(pick_valid), .pick_slot(pick_slot), .pick_core(pick_core)
    );

    // decision state machine
    dec_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (|ent_valid) state_d = S_SCORE;
            S_SCORE: state_d = S_ISSUE;
            S_ISSUE: state_d = (|ent_valid) ? S_SCORE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_slot  <= '0;
            grant_core  <= '0;
            for (int c = 0; c < NCORE; c++) score_q[c] <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:  grant_valid <= 1'b0;
                S_SCORE: for (int c = 0; c < NCORE; c++) score_q[c] <= score_now[c];
                S_ISSUE: begin
                    grant_valid <= pick_valid;
                    grant_slot  <= pick_slot;
                    grant_core  <= pick_core;
                end
                default: grant_valid <= 1'b0;
            endcase
        end
    end

    // R12
    score_then_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_SCORE |=> state_q == S_ISSUE);

    // R9
    no_ready_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISSUE && !(|(ent_valid & ready_mask))) |=> !grant_valid);

    // R10
    wt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_we && wt_idx <= 3'(NFEAT)) |=>
            theta[$past(wt_core)][$past(wt_idx)] == $past(wt_data));

    // R11
    deq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !(enq_valid && enq_slot == deq_slot)) |=>
            !ent_valid[$past(deq_slot)]);
endmodule

// File: tb/tb_core_learned_sched.sv
module tb_core_learned_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_valid = 1'b0, enq_hit = 1'b0, deq_valid = 1'b0, wt_we = 1'b0;
    logic [2:0] enq_slot = '0, deq_slot = '0, wt_idx = '0;
    logic [1:0] enq_core = '0, enq_bank = '0, wt_core = '0;
    logic [7:0] ready_mask = '0;
    logic [15:0] wt_data = '0;
    logic       grant_valid;
    logic [2:0] grant_slot;
    logic [1:0] grant_core;

    always #2 clk = ~clk;

    core_learned_sched dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_slot(enq_slot), .enq_core(enq_core),
        .enq_bank(enq_bank), .enq_hit(enq_hit),
        .deq_valid(deq_valid), .deq_slot(deq_slot), .ready_mask(ready_mask),
        .wt_we(wt_we), .wt_core(wt_core), .wt_idx(wt_idx), .wt_data(wt_data),
        .grant_valid(grant_valid), .grant_slot(grant_slot), .grant_core(grant_core)
    );

    int n_chk = 0, n_bad = 0;
    int th [4][5];
    bit m_valid [8];
    bit m_hit [8];
    int m_core [8], m_bank [8], m_seq [8];
    int seq_ctr = 0;
    logic [31:0] rs = 32'h1234_5678;

    function automatic int unsigned nxt();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic check_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic enq(int slot, int core, int bank, bit hit);
        @(negedge clk);
        enq_valid = 1'b1; enq_slot = 3'(slot); enq_core = 2'(core);
        enq_bank = 2'(bank); enq_hit = hit;
        @(negedge clk);
        enq_valid = 1'b0;
        m_valid[slot] = 1'b1; m_core[slot] = core; m_bank[slot] = bank;
        m_hit[slot] = hit; m_seq[slot] = seq_ctr; seq_ctr++;
    endtask

    task automatic deq(int slot);
        @(negedge clk);
        deq_valid = 1'b1; deq_slot = 3'(slot);
        @(negedge clk);
        deq_valid = 1'b0;
        m_valid[slot] = 1'b0;
    endtask

    task automatic wr_wt(int core, int idx, int val);
        @(negedge clk);
        wt_we = 1'b1; wt_core = 2'(core); wt_idx = 3'(idx); wt_data = 16'(val);
        @(negedge clk);
        wt_we = 1'b0;
        if (idx <= 4) th[core][idx] = val;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 8; s++) if (m_valid[s]) deq(s);
    endtask

    task automatic zero_weights();
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) wr_wt(c, k, 0);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // expected grant from R2..R8, history feature taken as zero
    task automatic model_pick(output bit v, output int slot, output int core);
        int np [4], nh [4], sc [4];
        bit busy [4];
        bit crdy [4];
        int nb, best;
        bit found, bhit;
        int bseq;
        nb = 0;
        for (int b = 0; b < 4; b++) busy[b] = 1'b0;
        for (int c = 0; c < 4; c++) begin np[c] = 0; nh[c] = 0; crdy[c] = 1'b0; end
        for (int s = 0; s < 8; s++) begin
            if (m_valid[s]) begin
                busy[m_bank[s]] = 1'b1;
                np[m_core[s]]++;
                if (m_hit[s]) nh[m_core[s]]++;
                if (ready_mask[s]) crdy[m_core[s]] = 1'b1;
            end
        end
        for (int b = 0; b < 4; b++) if (busy[b]) nb++;
        for (int c = 0; c < 4; c++)
            sc[c] = th[c][0] + th[c][1]*np[c] + th[c][2]*nh[c] + th[c][4]*nb;
        v = 1'b0; core = 0; best = 0;
        for (int c = 0; c < 4; c++)
            if (crdy[c] && (!v || sc[c] > best)) begin v = 1'b1; best = sc[c]; core = c; end
        found = 1'b0; bhit = 1'b0; bseq = 0; slot = 0;
        for (int s = 0; s < 8; s++) begin
            if (v && m_valid[s] && ready_mask[s] && m_core[s] == core &&
                (!found || (m_hit[s] && !bhit) || (m_hit[s] == bhit && m_seq[s] < bseq))) begin
                found = 1'b1; bhit = m_hit[s]; bseq = m_seq[s]; slot = s;
            end
        end
    endtask

    task automatic check_model(string tag);
        bit v; int s, c;
        model_pick(v, s, c);
        check_int({tag, " valid"}, int'(grant_valid), int'(v));
        if (v) begin
            check_int({tag, " core"}, int'(grant_core), c);
            check_int({tag, " slot"}, int'(grant_slot), s);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int s = 0; s < 8; s++) begin m_valid[s] = 1'b0; m_hit[s] = 1'b0; end
        for (int c = 0; c < 4; c++) for (int k = 0; k < 5; k++) th[c][k] = 0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check_int("R1 reset grant_valid", int'(grant_valid), 0);

        // R1 zero weights, R7 tie to lower core
        ready_mask = 8'hFF;
        enq(5, 2, 0, 1'b1);
        enq(3, 1, 1, 1'b0);
        idle(6);
        check_int("R1 R7 tie core", int'(grant_core), 1);
        check_int("R1 R7 tie slot", int'(grant_slot), 3);

        // R9 nothing ready
        ready_mask = 8'h00;
        idle(6);
        check_int("R9 no ready", int'(grant_valid), 0);
        ready_mask = 8'hFF;
        clear_all();
        idle(6);
        check_int("R12 drained queue", int'(grant_valid), 0);

        // R8 ordering inside one core
        enq(4, 1, 0, 1'b0);
        enq(2, 1, 1, 1'b0);
        enq(6, 1, 2, 1'b1);
        enq(7, 1, 3, 1'b1);
        idle(6);
        check_int("R8 row hit first", int'(grant_slot), 6);
        deq(6); idle(6);
        check_int("R8 remaining hit", int'(grant_slot), 7);
        deq(7); idle(6);
        check_int("R8 oldest not lowest", int'(grant_slot), 4);
        ready_mask = 8'hEF; idle(6);
        check_int("R8 skip not ready", int'(grant_slot), 2);
        ready_mask = 8'hFF;
        clear_all();

        // R4 history of arrivals
        for (int c = 0; c < 2; c++) wr_wt(c, 3, 256);
        enq(0, 0, 0, 1'b0);
        idle(20);
        enq(1, 1, 1, 1'b0);
        enq(2, 1, 2, 1'b0);
        enq(3, 1, 3, 1'b0);
        idle(4);
        check_int("R4 recent arrivals win", int'(grant_core), 1);
        idle(20);
        check_int("R4 history decayed", int'(grant_core), 0);
        clear_all();
        zero_weights();

        // R10 weight updates
        enq(0, 0, 0, 1'b0);
        enq(1, 3, 1, 1'b0);
        idle(6);
        check_int("R10 base", int'(grant_core), 0);
        wr_wt(3, 0, 1); idle(6);
        check_int("R10 bias raised", int'(grant_core), 3);
        wr_wt(0, 0, 2); idle(6);
        check_int("R10 other bias", int'(grant_core), 0);
        wr_wt(0, 0, -5); idle(6);
        check_int("R10 negative bias", int'(grant_core), 3);
        wr_wt(0, 6, 100); idle(6);
        check_int("R10 bad index ignored", int'(grant_core), 3);
        wr_wt(0, 0, 2); idle(6);

        // R11 queue events
        deq(0); idle(6);
        check_int("R11 dequeue core", int'(grant_core), 3);
        check_int("R11 dequeue slot", int'(grant_slot), 1);
        @(negedge clk);
        enq_valid = 1'b1; enq_slot = 3'd1; enq_core = 2'd2; enq_bank = 2'd0; enq_hit = 1'b0;
        deq_valid = 1'b1; deq_slot = 3'd1;
        @(negedge clk);
        enq_valid = 1'b0; deq_valid = 1'b0;
        m_core[1] = 2; m_bank[1] = 0; m_hit[1] = 1'b0; m_seq[1] = seq_ctr; seq_ctr++;
        idle(6);
        check_int("R11 same-cycle valid", int'(grant_valid), 1);
        check_int("R11 same-cycle core", int'(grant_core), 2);
        deq(6); idle(6);
        check_int("R11 free dequeue core", int'(grant_core), 2);
        check_int("R11 free dequeue slot", int'(grant_slot), 1);
        clear_all();

        // sweep over occupancy, banks, hits, readiness and weights
        for (int p = 0; p < 80; p++) begin
            int unsigned occ;
            clear_all();
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < 5; k++)
                    wr_wt(c, k, int'(nxt() % 1024) - 512);
            occ = nxt();
            for (int s = 0; s < 8; s++) begin
                if (occ[s] || s == p % 8) begin
                    int unsigned r;
                    r = nxt();
                    enq(s, int'(r % 4), int'((r >> 4) % 4), r[9]);
                end
            end
            ready_mask = 8'(nxt());
            if (p % 5 == 0) ready_mask = 8'hFF;
            idle(20);
            check_model("R2 R3 R5 R6 R7 R8 sweep");
        end

        report();
    end
endmodule